// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This block is the arithmetic and logic stage of an accumulator-based processor. Each cycle it takes the accumulator value, a second operand (a memory value or another register, routed by the surrounding datapath), a carry input, a 4-bit operation code and a byte-mode select. The byte-mode select is normally driven from the accumulator-size status flag. From these it produces a result word, the four condition flags N, V, Z and C, and one update enable per flag. The register file uses the enables to leave the flags an operation does not touch unchanged.

The operating width changes at run time. In word mode every operation uses the full data width. In byte mode only the low byte takes part: N comes from bit 7, Z and C are judged on the low byte, and the upper byte of the result is the accumulator's upper byte. Single-operand operations (shifts, rotates, increment, decrement) and the bit set/clear operations act on the operand input, so the datapath can route either the accumulator or memory there. All outputs are registered, and a result appears one clock after its inputs.

Top module: `dual_width_alu`

## Requirements
- R1: Op 0 (add) produces acc + operand + carry_in. It raises all four update enables. C is the carry out of the active width. V is set when acc and operand have the same sign bit and the result's sign bit differs from it.
- R2: Op 1 (subtract) produces acc - operand - (1 - carry_in) and raises all four enables. C is 1 when no borrow occurred. V is the add rule applied to acc and the inverted operand.
- R3: Ops 2, 3 and 4 (AND, OR, XOR of acc and operand) raise only the N and Z enables.
- R4: Op 5 (compare) forms acc - operand without writing it: the result output equals acc. N is the difference's top bit, Z is set on equality, C is 1 exactly when acc >= operand as unsigned values. The enables are N, Z and C.
- R5: Op 6 (immediate bit test) raises only the Z enable, with Z = ((acc AND operand) == 0). Op 7 (memory bit test) also raises N and V, which copy the operand's top bit and the bit below it. Both output acc as the result.
- R6: Op 8 (shift left) and op 9 (logical shift right) shift the operand by one bit. The vacated bit is filled with 0, C receives the bit shifted out, and the enables are N, Z and C.
- R7: Op 10 (rotate left) puts carry_in into bit 0, and op 11 (rotate right) puts carry_in into the top bit of the active width. C receives the bit shifted out, and the enables are N, Z and C.
- R8: Op 12 (increment) and op 13 (decrement) add or subtract one from the operand, wrapping at the active width. Only the N and Z enables are raised.
- R9: Op 14 (bit set) produces operand OR acc, and op 15 (bit clear) produces operand AND NOT acc. Both raise only the Z enable, with Z = ((acc AND operand) == 0).
- R10: With byte_mode_i = 1, N is bit 7 and Z and C are computed on bits 7:0. Bits 15:8 of the result equal bits 15:8 of acc for every op.
- R11: A flag output whose update enable is low is driven 0.
- R12: Outputs update one clock after the inputs are sampled. A synchronous active-high reset clears the result, all flags and all enables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode_i | input | 1 | 1 = 8-bit operation, 0 = full width |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Second operand / shift source |
| carry_i | input | 1 | Carry flag input |
| result_o | output | 16 | Registered result |
| flag_n_o | output | 1 | Negative flag value |
| flag_v_o | output | 1 | Overflow flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_c_o | output | 1 | Carry flag value |
| upd_n_o | output | 1 | N update enable |
| upd_v_o | output | 1 | V update enable |
| upd_z_o | output | 1 | Z update enable |
| upd_c_o | output | 1 | C update enable |

## Verification
The bound properties check on every cycle the rules that hold whatever the data: per-operation enable sets, zeroed flags under a low enable, preservation of the accumulator's upper byte in byte mode, the accumulator being passed through on compare and bit test, and reset clearing. Arithmetic values, carry and overflow at both widths, rotate carry threading and the Z rule of the bit operations need concrete operands. Those are covered only by the bench's random and directed vectors, which include the sign-boundary and all-ones cases.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_TSTI = 4'd6,
    OP_TSTM = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ROTL = 4'd10,
    OP_ROTR = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13,
    OP_SETB = 4'd14,
    OP_CLRB = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  logic [NARROW_W:0] nsum;
  logic [DATA_W:0]   wsum;
  logic sa, sb, sr;

  always_comb begin
    nsum = {1'b0, a[NARROW_W-1:0]} + {1'b0, b[NARROW_W-1:0]} + {{NARROW_W{1'b0}}, cin};
    wsum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    if (byte_mode) begin
      sum  = {wsum[DATA_W-1:NARROW_W], nsum[NARROW_W-1:0]};
      cout = nsum[NARROW_W];
      sa   = a[NARROW_W-1];
      sb   = b[NARROW_W-1];
      sr   = nsum[NARROW_W-1];
    end else begin
      sum  = wsum[DATA_W-1:0];
      cout = wsum[DATA_W];
      sa   = a[DATA_W-1];
      sb   = b[DATA_W-1];
      sr   = wsum[DATA_W-1];
    end
    ovf = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              byte_mode,
  input  logic              right,
  input  logic              rotate,
  input  logic              cin,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] out,
  output logic              cout
);
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (right) begin
      cout = val[0];
      if (byte_mode)
        out = {val[DATA_W-1:NARROW_W], fill, val[NARROW_W-1:1]};
      else
        out = {fill, val[DATA_W-1:1]};
    end else begin
      if (byte_mode) begin
        cout = val[NARROW_W-1];
        out  = {val[DATA_W-1:NARROW_W], val[NARROW_W-2:0], fill};
      end else begin
        cout = val[DATA_W-1];
        out  = {val[DATA_W-2:0], fill};
      end
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_r,
  output logic [DATA_W-1:0] or_r,
  output logic [DATA_W-1:0] xor_r,
  output logic [DATA_W-1:0] clr_r
);
  always_comb begin
    and_r = a & b;
    or_r  = a | b;
    xor_r = a ^ b;
    clr_r = b & ~a;
  end
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_v_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              upd_n_o,
  output logic              upd_v_o,
  output logic              upd_z_o,
  output logic              upd_c_o
);
  import alu_pkg::*;

  localparam int HI_W = DATA_W - NARROW_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  function automatic logic msb_of(input logic bm, input logic [DATA_W-1:0] x);
    return bm ? x[NARROW_W-1] : x[DATA_W-1];
  endfunction

  function automatic logic sub_msb_of(input logic bm, input logic [DATA_W-1:0] x);
    return bm ? x[NARROW_W-2] : x[DATA_W-2];
  endfunction

  function automatic logic is_zero(input logic bm, input logic [DATA_W-1:0] x);
    return bm ? (x[NARROW_W-1:0] == '0) : (x == '0);
  endfunction

  // Adder operand steering
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_cout, add_ovf;

  always_comb begin
    add_a   = acc_i;
    add_b   = opnd_i;
    add_cin = carry_i;
    case (op)
      OP_SUB: add_b = ~opnd_i;
      OP_CMP: begin
        add_b   = ~opnd_i;
        add_cin = 1'b1;
      end
      OP_INC: begin
        add_a   = opnd_i;
        add_b   = '0;
        add_cin = 1'b1;
      end
      OP_DEC: begin
        add_a   = opnd_i;
        add_b   = '1;
        add_cin = 1'b0;
      end
      default: ;
    endcase
  end

  alu_adder #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_adder (
    .byte_mode(byte_mode_i), .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  logic [DATA_W-1:0] sh_out;
  logic              sh_cout;
  logic              sh_right, sh_rot;
  assign sh_right = (op == OP_SHR) || (op == OP_ROTR);
  assign sh_rot   = (op == OP_ROTL) || (op == OP_ROTR);

  alu_shifter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_shift (
    .byte_mode(byte_mode_i), .right(sh_right), .rotate(sh_rot), .cin(carry_i),
    .val(opnd_i), .out(sh_out), .cout(sh_cout)
  );

  logic [DATA_W-1:0] and_r, or_r, xor_r, clr_r;
  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(acc_i), .b(opnd_i), .and_r(and_r), .or_r(or_r), .xor_r(xor_r), .clr_r(clr_r)
  );

  // Result and flag selection
  logic [DATA_W-1:0] raw, res_d;
  logic              keep_acc;
  flags_t            f, en, f_d;

  always_comb begin
    raw      = add_sum;
    keep_acc = 1'b0;
    f        = '0;
    en       = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        f.v = add_ovf;
        f.c = add_cout;
        en  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      end
      OP_AND: begin raw = and_r; en.n = 1'b1; en.z = 1'b1; end
      OP_OR:  begin raw = or_r;  en.n = 1'b1; en.z = 1'b1; end
      OP_XOR: begin raw = xor_r; en.n = 1'b1; en.z = 1'b1; end
      OP_CMP: begin
        keep_acc = 1'b1;
        f.c      = add_cout;
        en       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_TSTI: begin keep_acc = 1'b1; en.z = 1'b1; end
      OP_TSTM: begin
        keep_acc = 1'b1;
        f.v      = sub_msb_of(byte_mode_i, opnd_i);
        en       = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
        raw = sh_out;
        f.c = sh_cout;
        en  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      end
      OP_INC, OP_DEC: begin en.n = 1'b1; en.z = 1'b1; end
      OP_SETB: begin raw = or_r;  en.z = 1'b1; end
      OP_CLRB: begin raw = clr_r; en.z = 1'b1; end
      default: ;
    endcase

    if (op == OP_TSTM) f.n = msb_of(byte_mode_i, opnd_i);
    else               f.n = msb_of(byte_mode_i, raw);

    if (op == OP_TSTI || op == OP_TSTM || op == OP_SETB || op == OP_CLRB)
      f.z = is_zero(byte_mode_i, and_r);
    else
      f.z = is_zero(byte_mode_i, raw);

    f_d = f & en;

    if (keep_acc)         res_d = acc_i;
    else if (byte_mode_i) res_d = {acc_i[DATA_W-1:DATA_W-HI_W], raw[NARROW_W-1:0]};
    else                  res_d = raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      {flag_n_o, flag_v_o, flag_z_o, flag_c_o} <= '0;
      {upd_n_o, upd_v_o, upd_z_o, upd_c_o}     <= '0;
    end else begin
      result_o <= res_d;
      {flag_n_o, flag_v_o, flag_z_o, flag_c_o} <= f_d;
      {upd_n_o, upd_v_o, upd_z_o, upd_c_o}     <= en;
    end
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_mode_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_n_o,
  input logic              flag_v_o,
  input logic              flag_z_o,
  input logic              flag_c_o,
  input logic              upd_n_o,
  input logic              upd_v_o,
  input logic              upd_z_o,
  input logic              upd_c_o
);
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_o == '0) && !upd_n_o && !upd_v_o && !upd_z_o && !upd_c_o
            && !flag_n_o && !flag_v_o && !flag_z_o && !flag_c_o);

  // R11
  masked_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_n_o -> !flag_n_o) && (!upd_v_o -> !flag_v_o)
    && (!upd_z_o -> !flag_z_o) && (!upd_c_o -> !flag_c_o));

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    byte_mode_i |=> result_o[DATA_W-1:NARROW_W] == $past(acc_i[DATA_W-1:NARROW_W]));

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd5) |=> (result_o == $past(acc_i)) && upd_c_o && !upd_v_o);

  // R5
  bit_test_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd6) |=> (result_o == $past(acc_i)) && upd_z_o && !upd_n_o && !upd_v_o && !upd_c_o);

  // R3
  logic_en_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2 || op_i == 4'd3 || op_i == 4'd4) |=>
      upd_n_o && upd_z_o && !upd_v_o && !upd_c_o);

  // R9
  bitop_en_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd14 || op_i == 4'd15) |=>
      upd_z_o && !upd_n_o && !upd_v_o && !upd_c_o);

  // R1
  add_en_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd0) |=> upd_n_o && upd_v_o && upd_z_o && upd_c_o);

  // R8
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd12 && !byte_mode_i && opnd_i == '1) |=> (result_o == '0) && flag_z_o);
endmodule

bind dual_width_alu alu_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_alu_chk (
  .clk(clk), .rst(rst), .byte_mode_i(byte_mode_i), .op_i(op_i), .acc_i(acc_i),
  .opnd_i(opnd_i), .result_o(result_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o),
  .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .upd_n_o(upd_n_o), .upd_v_o(upd_v_o),
  .upd_z_o(upd_z_o), .upd_c_o(upd_c_o)
);

// File: tb/test_dual_width_alu.sv
module test_dual_width_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_mode_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] acc_i = 16'h1234;
  logic [15:0] opnd_i = 16'h5678;
  logic        carry_i = 1'b1;
  logic [15:0] result_o;
  logic        flag_n_o, flag_v_o, flag_z_o, flag_c_o;
  logic        upd_n_o, upd_v_o, upd_z_o, upd_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_width_alu i_dual_width_alu (
    .clk(clk), .rst(rst), .byte_mode_i(byte_mode_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .carry_i(carry_i), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .upd_n_o(upd_n_o), .upd_v_o(upd_v_o), .upd_z_o(upd_z_o), .upd_c_o(upd_c_o)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      4'd10, 4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Packed expectation: {result[15:0], n, v, z, c, en_n, en_v, en_z, en_c}
  function automatic logic [23:0] model(input logic [3:0] op, input logic [15:0] acc,
                                        input logic [15:0] opnd, input logic cin,
                                        input logic bm);
    int w   = bm ? 8 : 16;
    int m   = bm ? 'hFF : 'hFFFF;
    int top = w - 1;
    int a   = int'(acc) & m;
    int b   = int'(opnd) & m;
    int r   = 0;
    int s;
    int bb;
    logic n = 0, v = 0, z = 0, c = 0;
    logic en_n = 0, en_v = 0, en_z = 0, en_c = 0;
    logic keep = 0;
    logic [15:0] full;
    case (op)
      4'd0, 4'd1: begin
        bb = (op == 4'd1) ? ((~b) & m) : b;
        s  = a + bb + int'(cin);
        r  = s & m;
        c  = ((s >> w) & 1) != 0;
        v  = (((a >> top) & 1) == ((bb >> top) & 1)) && (((r >> top) & 1) != ((a >> top) & 1));
        {en_n, en_v, en_z, en_c} = 4'b1111;
      end
      4'd2: begin r = a & b; {en_n, en_z} = 2'b11; end
      4'd3: begin r = a | b; {en_n, en_z} = 2'b11; end
      4'd4: begin r = a ^ b; {en_n, en_z} = 2'b11; end
      4'd5: begin
        keep = 1; r = (a - b) & m; c = (a >= b);
        {en_n, en_z, en_c} = 3'b111;
      end
      4'd6: begin keep = 1; en_z = 1; end
      4'd7: begin keep = 1; {en_n, en_v, en_z} = 3'b111; end
      4'd8:  begin r = (b << 1) & m; c = ((b >> top) & 1) != 0; {en_n, en_z, en_c} = 3'b111; end
      4'd9:  begin r = b >> 1; c = (b & 1) != 0; {en_n, en_z, en_c} = 3'b111; end
      4'd10: begin r = ((b << 1) | int'(cin)) & m; c = ((b >> top) & 1) != 0; {en_n, en_z, en_c} = 3'b111; end
      4'd11: begin r = (b >> 1) | (int'(cin) << top); c = (b & 1) != 0; {en_n, en_z, en_c} = 3'b111; end
      4'd12: begin r = (b + 1) & m; {en_n, en_z} = 2'b11; end
      4'd13: begin r = (b - 1) & m; {en_n, en_z} = 2'b11; end
      4'd14: begin r = b | a; en_z = 1; end
      default: begin r = b & (~a) & m; en_z = 1; end
    endcase
    if (op == 4'd7) begin
      n = ((b >> top) & 1) != 0;
      v = ((b >> (top - 1)) & 1) != 0;
    end else begin
      n = ((r >> top) & 1) != 0;
    end
    if (op == 4'd6 || op == 4'd7 || op == 4'd14 || op == 4'd15) z = ((a & b) == 0);
    else if (op == 4'd5) z = (a == b);
    else z = (r == 0);
    if (keep)    full = acc;
    else if (bm) full = {acc[15:8], 8'(r)};
    else         full = 16'(r);
    return {full, n & en_n, v & en_v, z & en_z, c & en_c, en_n, en_v, en_z, en_c};
  endfunction

  task automatic run_vec(input logic [3:0] op, input logic [15:0] acc,
                         input logic [15:0] opnd, input logic cin, input logic bm);
    logic [23:0] exp_v, act_v;
    @(negedge clk);
    op_i = op; acc_i = acc; opnd_i = opnd; carry_i = cin; byte_mode_i = bm;
    exp_v = model(op, acc, opnd, cin, bm);
    @(negedge clk);
    act_v = {result_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o,
             upd_n_o, upd_v_o, upd_z_o, upd_c_o};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s%s op=%0d acc=%h opnd=%h cin=%0b: actual %h expected %h",
               tag_of(op), bm ? " R10" : "", op, acc, opnd, cin, act_v, exp_v);
    end
    // R11: a flag whose enable is low must read 0
    checks++;
    if ((flag_n_o & ~upd_n_o) | (flag_v_o & ~upd_v_o) | (flag_z_o & ~upd_z_o) | (flag_c_o & ~upd_c_o)) begin
      errors++;
      $display("FAIL R11 flags=%b%b%b%b enables=%b%b%b%b expected masked flags",
               flag_n_o, flag_v_o, flag_z_o, flag_c_o, upd_n_o, upd_v_o, upd_z_o, upd_c_o);
    end
  endtask

  initial begin : watchdog
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    // R12: reset clears every output
    checks++;
    if ({result_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, upd_n_o, upd_v_o, upd_z_o, upd_c_o} !== 24'h0) begin
      errors++;
      $display("FAIL R12 reset state: actual %h expected 000000",
               {result_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, upd_n_o, upd_v_o, upd_z_o, upd_c_o});
    end
    rst = 1'b0;

    // Directed corners
    run_vec(4'd0, 16'hAB7F, 16'h0001, 1'b0, 1'b1);  // R1 byte signed overflow
    run_vec(4'd0, 16'hFFFF, 16'h0000, 1'b1, 1'b0);  // R1 word carry, zero
    run_vec(4'd0, 16'h00FF, 16'h0001, 1'b0, 1'b1);  // R10 byte carry, upper kept
    run_vec(4'd1, 16'h8000, 16'h0001, 1'b1, 1'b0);  // R2 overflow
    run_vec(4'd1, 16'h0000, 16'h0000, 1'b0, 1'b0);  // R2 borrow in
    run_vec(4'd5, 16'h0020, 16'h0020, 1'b0, 1'b1);  // R4 equal
    run_vec(4'd5, 16'h0010, 16'h8000, 1'b1, 1'b0);  // R4 less
    run_vec(4'd6, 16'h0010, 16'h0080, 1'b0, 1'b0);  // R5 immediate
    run_vec(4'd7, 16'h0001, 16'h00C1, 1'b0, 1'b1);  // R5 memory byte
    run_vec(4'd7, 16'h0000, 16'h4000, 1'b0, 1'b0);  // R5 memory word
    run_vec(4'd8, 16'h1200, 16'h0080, 1'b0, 1'b1);  // R6 byte shift out
    run_vec(4'd9, 16'h0000, 16'h0001, 1'b1, 1'b0);  // R6 right, carry ignored
    run_vec(4'd10, 16'h0000, 16'h8000, 1'b0, 1'b0); // R7 17-bit wrap
    run_vec(4'd11, 16'h0000, 16'h0001, 1'b1, 1'b0); // R7 carry to bit 15
    run_vec(4'd11, 16'h5500, 16'h0001, 1'b1, 1'b1); // R7 carry to bit 7
    run_vec(4'd12, 16'hCD00, 16'h00FF, 1'b0, 1'b1); // R8 byte wrap
    run_vec(4'd13, 16'h0000, 16'h0000, 1'b0, 1'b0); // R8 word wrap
    run_vec(4'd14, 16'h00F0, 16'h000F, 1'b0, 1'b0); // R9 set, no overlap
    run_vec(4'd15, 16'h00F0, 16'h00FF, 1'b0, 1'b0); // R9 clear, overlap

    // Random vectors
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  rop  = 4'($urandom_range(0, 15));
      logic [15:0] racc = 16'($urandom);
      logic [15:0] ropd = 16'($urandom);
      logic        rcin = 1'($urandom);
      logic        rbm  = 1'($urandom);
      run_vec(rop, racc, ropd, rcin, rbm);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule